// File: doc/BRIEF.md
# Clock Ratio and Speed-Mode Detector

This block watches a frame clock (one period per stereo sample) from the side of a free-running system clock. It counts system-clock cycles between successive rising frame-clock edges and compares the count with a fixed set of permitted ratios. Because those ratios include non-power-of-two values, the set is 32, 64, 128, 192, 256, 384, 512, 768 and 1024. A small tolerance window lets the block accept system clocks that are not exact multiples of the sample rate.

A second count classifies the frame period as double or single speed. This count gathers strobes from a fixed reference clock over the same frame period. The two lowest ratios are refused in double-speed mode. The block declares the clock setup good only after several identical frames in a row, and withdraws that verdict at the first frame that disagrees. If the frame clock stops, the block flags it as missing. Downstream logic reads the valid flag, the ratio code and the speed flag to decide whether, and how, to run the audio path.

Top module: `clk_ratio_detect`

## Requirements
- R1: The frame period is the number of `sys_clk` cycles between two rising `lrck_i` edges. It is reported as a ratio code: 0=32, 1=64, 2=128, 3=192, 4=256, 5=384, 6=512, 7=768, 8=1024.
- R2: A period within ±TOLERANCE (default 2) cycles of a permitted ratio matches that ratio. A period outside every window is an invalid measurement.
- R3: The block counts `ref_tick_i` strobes over the frame period. A count below `dbl_thresh_i` sets `double_speed_o`=1; otherwise the measurement is single speed.
- R4: In double speed, codes 0 and 1 (ratios 32 and 64) are invalid measurements.
- R5: `clk_valid_o` rises only after STABLE_FRAMES (default 4) consecutive valid measurements with the same code and speed.
- R6: One invalid measurement, or one that differs in code or speed, drops `clk_valid_o` at once. A differing valid measurement starts a new run of one.
- R7: If no rising `lrck_i` edge comes for LOSS_LIMIT (default 2048) cycles, `lrck_missing_o`=1 and `clk_valid_o`=0.
- R8: After reset or after a loss, the first rising edge only starts a new period and produces no measurement. That edge clears `lrck_missing_o`.
- R9: During and right after reset all outputs are 0.
- R10: While `clk_valid_o` stays high, `ratio_code_o` and `double_speed_o` do not change. They keep the last valid measurement when the block is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock; the measurement time base |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_i | input | 1 | Frame clock, asynchronous to `sys_clk` |
| ref_tick_i | input | 1 | One-cycle strobe from a fixed reference clock, already in the `sys_clk` domain |
| dbl_thresh_i | input | REF_W | Reference-strobe count below which a frame counts as double speed |
| clk_valid_o | output | 1 | Clock setup confirmed stable and permitted |
| ratio_code_o | output | 4 | Code of the matched ratio (see R1) |
| double_speed_o | output | 1 | 1 = double-speed mode |
| lrck_missing_o | output | 1 | Frame clock declared lost |

## Verification
A rising frame edge can close a period in the same cycle the loss timer would run out. The same edge can also be the first one after a loss, where it must clear the missing flag but yield no measurement. The bench stops the frame clock long enough to trigger the loss, then restarts it. The scoreboard expects the missing flag to clear at the first edge and the valid flag to stay low until four fresh measurements agree. The speed decision and the ratio legality are also settled in the same cycle. Frames of 32 and 64 cycles are therefore driven with a sparse reference strobe, and each must read as invalid, not as a valid slow-ratio result.

// File: rtl/crd_pkg.sv
// Shared constants for the clock ratio detector.
// Assumes: the permitted ratio set is fixed; codes index it in ascending order.
package crd_pkg;
    localparam int RATIO_COUNT    = 9;
    localparam int CODE_W         = 4;
    // codes below this value are refused in double-speed mode
    localparam int DBL_FIRST_CODE = 2;

    // Ratio for a code: 32, 64, then 128*2^k and 192*2^k alternating.
    function automatic int legal_ratio(input int idx);
        int base;
        if (idx == 0) return 32;
        if (idx == 1) return 64;
        base = 128 << ((idx - 2) / 2);
        return (idx % 2 == 1) ? base + base / 2 : base;
    endfunction
endpackage

// File: rtl/crd_edge_sync.sv
// Brings the asynchronous frame clock into the system clock domain and
// gives a one-cycle pulse for each rising edge.
// Assumes: the frame clock is high and low for at least 2 system cycles.
module crd_edge_sync (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic lrck_i,
    output logic rise_o
);
    logic [2:0] shift_q;

    // two synchroniser stages and one history stage
    always_ff @(posedge sys_clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[1:0], lrck_i};
    end

    assign rise_o = shift_q[1] & ~shift_q[2];
endmodule

// File: rtl/crd_period_meas.sv
// Counts system cycles and reference strobes between rising frame edges.
// Raises a timeout when no edge arrives for LOSS_LIMIT cycles.
// Assumes: rise_i is a single-cycle pulse; ref_tick_i is synchronous.
module crd_period_meas #(
    parameter int LOSS_LIMIT = 2048,
    parameter int REF_W      = 12,
    parameter int CNT_W      = $clog2(LOSS_LIMIT + 2)
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             ref_tick_i,
    output logic [CNT_W-1:0] period_o,
    output logic [REF_W-1:0] ref_count_o,
    output logic             meas_vld_o,
    output logic             timeout_o,
    output logic             missing_o
);
    logic [CNT_W-1:0] cyc_cnt;
    logic [REF_W-1:0] ref_cnt;
    logic [REF_W-1:0] ref_next;
    logic             started;

    assign timeout_o = (cyc_cnt == CNT_W'(LOSS_LIMIT)) && !rise_i;
    assign ref_next  = (ref_tick_i && (ref_cnt != '1)) ? ref_cnt + 1'b1 : ref_cnt;

    // system-cycle counter, saturating at the loss limit
    always_ff @(posedge sys_clk) begin
        if (!rst_n)          cyc_cnt <= '0;
        else if (rise_i)     cyc_cnt <= '0;
        else if (!timeout_o) cyc_cnt <= cyc_cnt + 1'b1;
    end

    // reference-strobe counter over the same window
    always_ff @(posedge sys_clk) begin
        if (!rst_n)      ref_cnt <= '0;
        else if (rise_i) ref_cnt <= '0;
        else             ref_cnt <= ref_next;
    end

    // capture both counts at each edge once a period has been opened
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            period_o    <= '0;
            ref_count_o <= '0;
            meas_vld_o  <= 1'b0;
        end else begin
            meas_vld_o <= rise_i && started;
            if (rise_i) begin
                period_o    <= cyc_cnt + 1'b1;
                ref_count_o <= ref_next;
            end
        end
    end

    // open/closed period state and the missing flag
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            missing_o <= 1'b0;
        end else if (rise_i) begin
            started   <= 1'b1;
            missing_o <= 1'b0;
        end else if (timeout_o) begin
            started   <= 1'b0;
            missing_o <= 1'b1;
        end
    end
endmodule

// File: rtl/crd_ratio_match.sv
// Matches a measured period to the permitted ratio set within a tolerance.
// Assumes: ratio spacing exceeds twice the tolerance, so at most one hit.
module crd_ratio_match #(
    parameter int CNT_W     = 12,
    parameter int TOLERANCE = 2
) (
    input  logic [CNT_W-1:0]           period_i,
    output logic                       hit_o,
    output logic [crd_pkg::CODE_W-1:0] code_o
);
    import crd_pkg::*;

    logic [RATIO_COUNT-1:0] hits;

    // one window comparator per permitted ratio
    for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_win
        localparam int LO = legal_ratio(g) - TOLERANCE;
        localparam int HI = legal_ratio(g) + TOLERANCE;
        assign hits[g] = (int'(period_i) >= LO) && (int'(period_i) <= HI);
    end

    // encode the hit vector into a code
    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        for (int i = 0; i < RATIO_COUNT; i++) begin
            if (hits[i]) begin
                hit_o  = 1'b1;
                code_o = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/crd_stability.sv
// Qualifies measurements: valid after STABLE_N identical permitted results,
// cleared by any differing or refused result, or by a frame clock timeout.
// Assumes: meas_vld_i pulses once per measured period.
module crd_stability #(
    parameter int STABLE_N = 4
) (
    input  logic                       sys_clk,
    input  logic                       rst_n,
    input  logic                       meas_vld_i,
    input  logic                       hit_i,
    input  logic [crd_pkg::CODE_W-1:0] code_i,
    input  logic                       dbl_i,
    input  logic                       timeout_i,
    output logic                       valid_o,
    output logic [crd_pkg::CODE_W-1:0] code_o,
    output logic                       dbl_o
);
    import crd_pkg::*;

    localparam int STREAK_W = $clog2(STABLE_N + 1);

    logic [STREAK_W-1:0] streak;
    logic                permitted;
    logic                same;

    assign permitted = hit_i && !(dbl_i && (int'(code_i) < DBL_FIRST_CODE));
    assign same      = (streak != '0) && (code_i == code_o) && (dbl_i == dbl_o);
    assign valid_o   = (streak == STREAK_W'(STABLE_N));

    // run-length of identical permitted measurements
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            streak <= '0;
            code_o <= '0;
            dbl_o  <= 1'b0;
        end else if (timeout_i) begin
            streak <= '0;
        end else if (meas_vld_i) begin
            if (permitted) begin
                code_o <= code_i;
                dbl_o  <= dbl_i;
                if (!same)        streak <= STREAK_W'(1);
                else if (!valid_o) streak <= streak + 1'b1;
            end else begin
                streak <= '0;
            end
        end
    end
endmodule

// File: rtl/clk_ratio_detect.sv
// Top of the clock ratio and speed-mode detector. Measures the frame period
// in system cycles, matches it to the permitted ratio set, classifies speed
// from a reference-strobe count and qualifies the result over several frames.
// Assumes: sys_clk runs freely; ref_tick_i is synchronous to sys_clk.
module clk_ratio_detect #(
    parameter int LOSS_LIMIT    = 2048,
    parameter int TOLERANCE     = 2,
    parameter int STABLE_FRAMES = 4,
    parameter int REF_W         = 12
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             lrck_i,
    input  logic             ref_tick_i,
    input  logic [REF_W-1:0] dbl_thresh_i,
    output logic             clk_valid_o,
    output logic [3:0]       ratio_code_o,
    output logic             double_speed_o,
    output logic             lrck_missing_o
);
    import crd_pkg::*;

    localparam int CNT_W = $clog2(LOSS_LIMIT + 2);

    logic              rise;
    logic [CNT_W-1:0]  period;
    logic [REF_W-1:0]  ref_count;
    logic              meas_vld;
    logic              timeout;
    logic              hit;
    logic [CODE_W-1:0] code;
    logic              meas_dbl;

    crd_edge_sync u_sync (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .lrck_i  (lrck_i),
        .rise_o  (rise)
    );

    crd_period_meas #(
        .LOSS_LIMIT (LOSS_LIMIT),
        .REF_W      (REF_W),
        .CNT_W      (CNT_W)
    ) u_meas (
        .sys_clk     (sys_clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .ref_tick_i  (ref_tick_i),
        .period_o    (period),
        .ref_count_o (ref_count),
        .meas_vld_o  (meas_vld),
        .timeout_o   (timeout),
        .missing_o   (lrck_missing_o)
    );

    crd_ratio_match #(
        .CNT_W     (CNT_W),
        .TOLERANCE (TOLERANCE)
    ) u_match (
        .period_i (period),
        .hit_o    (hit),
        .code_o   (code)
    );

    // few reference strobes per frame means a short frame: double speed
    assign meas_dbl = (ref_count < dbl_thresh_i);

    crd_stability #(
        .STABLE_N (STABLE_FRAMES)
    ) u_qual (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .meas_vld_i (meas_vld),
        .hit_i      (hit),
        .code_i     (code),
        .dbl_i      (meas_dbl),
        .timeout_i  (timeout),
        .valid_o    (clk_valid_o),
        .code_o     (ratio_code_o),
        .dbl_o      (double_speed_o)
    );
endmodule

// File: rtl/crd_checker.sv
// Temporal checks on the detector outputs, bound to the top module.
module crd_checker (
    input logic       sys_clk,
    input logic       rst_n,
    input logic       clk_valid_o,
    input logic [3:0] ratio_code_o,
    input logic       double_speed_o,
    input logic       lrck_missing_o
);
    // the reported code always indexes the permitted set
    assert_code_in_set_R1: assert property (@(posedge sys_clk) disable iff (!rst_n)
        int'(ratio_code_o) < crd_pkg::RATIO_COUNT);

    // a valid double-speed result never carries the two lowest ratios
    assert_dbl_no_low_ratio_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (clk_valid_o && double_speed_o) |-> (int'(ratio_code_o) >= crd_pkg::DBL_FIRST_CODE));

    // a lost frame clock and a valid verdict never coexist
    assert_missing_not_valid_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        lrck_missing_o |-> !clk_valid_o);

    // the edge that ends a loss gives no verdict by itself
    assert_first_edge_no_valid_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(lrck_missing_o) |-> !clk_valid_o);

    // reported setup holds while valid stays high
    assert_hold_while_valid_R10: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (clk_valid_o && $past(clk_valid_o)) |-> ($stable(ratio_code_o) && $stable(double_speed_o)));
endmodule

bind clk_ratio_detect crd_checker u_crd_checker (
    .sys_clk        (sys_clk),
    .rst_n          (rst_n),
    .clk_valid_o    (clk_valid_o),
    .ratio_code_o   (ratio_code_o),
    .double_speed_o (double_speed_o),
    .lrck_missing_o (lrck_missing_o)
);

// File: tb/tb_clk_ratio_detect.sv
// Scoreboard bench: the frame driver predicts each verdict and queues it,
// the monitor checks it a fixed number of cycles after the frame edge.
module tb_clk_ratio_detect;
    localparam int THRESH = 24;
    localparam int TOL    = 2;
    localparam int STABLE = 4;

    logic        sys_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck_i = 1'b0;
    logic        ref_tick_i = 1'b0;
    logic [11:0] dbl_thresh_i = 12'(THRESH);
    logic        clk_valid_o;
    logic [3:0]  ratio_code_o;
    logic        double_speed_o;
    logic        lrck_missing_o;

    int checks = 0;
    int fails = 0;

    typedef struct {
        bit    valid;
        int    code;
        bit    dbl;
        bit    missing;
        string req;
    } exp_t;

    exp_t q[$];

    // bench-side model state
    int ratios[9] = '{32, 64, 128, 192, 256, 384, 512, 768, 1024};
    bit m_started = 0;
    int m_streak = 0;
    int m_code = 0;
    bit m_dbl = 0;
    bit m_missing = 0;
    int prev_n = 0;
    bit prev_d = 0;

    clk_ratio_detect dut (
        .sys_clk        (sys_clk),
        .rst_n          (rst_n),
        .lrck_i         (lrck_i),
        .ref_tick_i     (ref_tick_i),
        .dbl_thresh_i   (dbl_thresh_i),
        .clk_valid_o    (clk_valid_o),
        .ratio_code_o   (ratio_code_o),
        .double_speed_o (double_speed_o),
        .lrck_missing_o (lrck_missing_o)
    );

    always #10 sys_clk = ~sys_clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check_out(input bit v, input int c, input bit d, input bit m, input string req);
        checks++;
        if (clk_valid_o !== v || int'(ratio_code_o) != c || double_speed_o !== d || lrck_missing_o !== m) begin
            fails++;
            $display("FAIL %s: valid/code/dbl/missing actual %0b/%0d/%0b/%0b expected %0b/%0d/%0b/%0b",
                     req, clk_valid_o, ratio_code_o, double_speed_o, lrck_missing_o, v, c, d, m);
        end
    endtask

    // model of one completed period (R1..R6)
    task automatic apply_measure(input int n, input bit d);
        int m = -1;
        for (int i = 0; i < 9; i++)
            if (n >= ratios[i] - TOL && n <= ratios[i] + TOL) m = i;
        if (m >= 0 && !(d && m < 2)) begin
            if (m_streak > 0 && m == m_code && d == m_dbl) begin
                if (m_streak < STABLE) m_streak++;
            end else begin
                m_streak = 1;
            end
            m_code = m;
            m_dbl  = d;
        end else begin
            m_streak = 0;
        end
    endtask

    // drive one frame of n cycles; d selects a sparse reference strobe
    task automatic drive_frame(input int n, input bit d, input string req);
        exp_t e;
        for (int k = 0; k < n; k++) begin
            @(negedge sys_clk);
            lrck_i     = (k < (n + 1) / 2);
            ref_tick_i = d ? (k % 64 == 0) : 1'b1;
            if (k == 0) begin
                if (m_started) apply_measure(prev_n, prev_d);
                m_started = 1;
                m_missing = 0;
                e.valid   = (m_streak >= STABLE);
                e.code    = m_code;
                e.dbl     = m_dbl;
                e.missing = m_missing;
                e.req     = req;
                q.push_back(e);
            end
        end
        prev_n = n;
        prev_d = d;
    endtask

    task automatic frames(input int n, input bit d, input int cnt, input string req);
        for (int i = 0; i < cnt; i++) drive_frame(n, d, req);
    endtask

    // monitor: result settles within 4 edges of the frame edge
    initial begin
        exp_t e;
        forever begin
            wait (q.size() > 0);
            e = q.pop_front();
            repeat (6) @(posedge sys_clk);
            @(negedge sys_clk);
            check_out(e.valid, e.code, e.dbl, e.missing, e.req);
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge sys_clk);
        fails++;
        $display("FAIL watchdog R5: run did not end, actual running expected finished");
        report();
        $finish;
    end

    initial begin
        repeat (5) @(negedge sys_clk);
        check_out(0, 0, 0, 0, "R9 in reset");
        rst_n = 1'b1;
        @(negedge sys_clk);
        check_out(0, 0, 0, 0, "R9 after reset");

        frames(256, 0, 6, "R5 R8 build-up");
        frames(256, 0, 2, "R10 hold");
        drive_frame(258, 0, "R2 upper edge");
        drive_frame(254, 0, "R2 lower edge");
        drive_frame(259, 0, "R2 just outside");
        frames(256, 0, 5, "R6 rebuild");
        frames(384, 0, 5, "R1 ratio 384");
        drive_frame(256, 0, "R6 single change");
        frames(256, 0, 4, "R6 restart");
        frames(30, 0, 5, "R1 R2 ratio 32 low");
        drive_frame(34, 0, "R2 ratio 32 high");
        frames(64, 0, 5, "R1 ratio 64");
        frames(128, 1, 5, "R3 double 128");
        frames(192, 1, 5, "R3 double 192");
        frames(64, 1, 5, "R4 double 64");
        frames(32, 1, 2, "R4 double 32");
        frames(1024, 1, 5, "R3 double 1024");
        frames(1026, 0, 5, "R1 R3 single 1024");
        frames(768, 0, 5, "R1 ratio 768");
        frames(512, 0, 5, "R1 ratio 512");
        frames(96, 0, 3, "R2 between ratios");
        frames(256, 0, 5, "R5 before loss");

        // stop the frame clock long enough for a loss (R7)
        @(negedge sys_clk);
        lrck_i     = 1'b0;
        ref_tick_i = 1'b0;
        repeat (2100) @(negedge sys_clk);
        m_started = 0;
        m_streak  = 0;
        m_missing = 1;
        check_out(0, m_code, m_dbl, 1, "R7 frame clock lost");

        frames(256, 0, 6, "R8 resume after loss");

        wait (q.size() == 0);
        repeat (10) @(negedge sys_clk);
        report();
        $finish;
    end
endmodule